// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a memory controller's ECC checker and keeps a record of the first error it reports. The checker signals a correctable (single-bit) or an uncorrectable (multi-bit) error with a one-cycle pulse. With the pulse it presents the failing address and the syndrome. The block stores the kind of error, the upper address bits and the syndrome. Later errors do not overwrite the record until software has cleared the status. Everything is visible through one 32-bit register that is read continuously and written with a single write strobe.

The same register holds three control bits. One enables an interrupt request for a captured correctable error. One enables a system-error output for a captured uncorrectable error. The third stops the scrub request that is otherwise sent to the write-back path on every corrected read. Register layout, from the most significant bit down:

- bit 31: scrub disable (read/write)
- bits 30:12: failing address bits 31:13 (read-only)
- bits 11:4: syndrome (read-only)
- bit 3: system-error enable (read/write)
- bit 2: interrupt enable (read/write)
- bit 1: multi-bit flag (write 1 to clear)
- bit 0: single-bit flag (write 1 to clear)

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous active-low reset, all 32 register bits read 0, and nmi_req_o, serr_o and scrub_req_o are 0.
- R2: A write stores wdata bit 31 as scrub disable, bit 3 as system-error enable and bit 2 as interrupt enable. The new values read back from the cycle after the write.
- R3: When both flags are 0 and only err_single_i pulses, the next cycle reads bit 0 = 1 and bit 1 = 0. Bits 30:12 then hold err_addr_i[31:13] and bits 11:4 hold err_syn_i, all sampled with the pulse.
- R4: When both flags are 0 and err_multi_i pulses, the next cycle reads bit 1 = 1 and bit 0 = 0. The address and syndrome fields are captured the same way as for a single-bit error.
- R5: If err_single_i and err_multi_i pulse in the same cycle while both flags are 0, only the multi-bit flag is set.
- R6: While either flag is 1, new error pulses are ignored. Bits 30:4 and 1:0 hold their values unless a write clears the flag that is set. An error arriving in the same cycle as that clearing write is also ignored.
- R7: Writing 1 to bit 1 or bit 0 clears that flag, and writing 0 leaves it unchanged. Capture resumes only once both flags read 0.
- R8: nmi_req_o is a level equal to bit 0 AND bit 2.
- R9: serr_o is a level equal to bit 1 AND bit 3.
- R10: In the same cycle as the pulse, scrub_req_o equals err_single_i AND NOT bit 31. This does not depend on whether the error is captured.
- R11: If an error pulse and a register write fall in the same cycle while both flags are 0, the error is captured and the written control bits take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_single_i | input | 1 | Correctable error pulse from the ECC checker |
| err_multi_i | input | 1 | Uncorrectable error pulse from the ECC checker |
| err_addr_i | input | ADDR_W | Failing address, valid with a pulse |
| err_syn_i | input | SYN_W | Syndrome, valid with a pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| nmi_req_o | output | 1 | Interrupt request for a captured correctable error |
| serr_o | output | 1 | System error for a captured uncorrectable error |
| scrub_req_o | output | 1 | Write-back scrub request for a corrected read |

## Verification
The bench builds the block with its default 32-bit address and 8-bit syndrome. With these values the address field is exactly 19 bits, and all three control bits plus both flags fit the fixed register. Under these values, random addresses and syndromes exercise every bit of both captured fields. Random write data exercises every combination of clear bits and enables, including writes that land in the same cycle as an error while the block is armed and while it is frozen.

// File: rtl/ecc_cap_pkg.sv
// Shared constants and types for the ECC error capture register.
// Assumes a fixed 32-bit register layout with the control bits at
// the edges and the two status flags in the lowest bits.
package ecc_cap_pkg;
    localparam int REG_W        = 32;
    localparam int BIT_SCRUB_DIS = 31;
    localparam int BIT_SERR_EN   = 3;
    localparam int BIT_NMI_EN    = 2;
    localparam int BIT_MBE       = 1;
    localparam int BIT_SBE       = 0;
    localparam int SYN_LSB       = 4;

    // Status encoding: bit 1 = multi-bit captured, bit 0 = single-bit captured
    typedef enum logic [1:0] {
        CAP_NONE = 2'b00,
        CAP_SBE  = 2'b01,
        CAP_MBE  = 2'b10
    } cap_kind_t;

    typedef struct packed {
        logic scrub_dis;
        logic serr_en;
        logic nmi_en;
    } ctrl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
// Control bit holder: scrub disable, system-error enable, interrupt enable.
// Assumes every write updates all three bits; there are no byte enables.
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_o
);
    ctrl_t ctrl_q;

    // Load the control bits on a write, clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.scrub_dis <= wdata[BIT_SCRUB_DIS];
            ctrl_q.serr_en   <= wdata[BIT_SERR_EN];
            ctrl_q.nmi_en    <= wdata[BIT_NMI_EN];
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ecc_cap_log.sv
// First-error logger. Captures kind, upper address bits and syndrome
// while no error is held; freezes until software clears the held flag.
// Assumes the checker presents address and syndrome with the pulse.
module ecc_cap_log
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8,
    parameter int LOG_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_single,
    input  logic              err_multi,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              wr_en,
    input  logic [1:0]        clr_bits,
    output cap_kind_t         kind_o,
    output logic [LOG_W-1:0]  addr_o,
    output logic [SYN_W-1:0]  syn_o
);
    cap_kind_t        kind_q;
    logic [LOG_W-1:0] addr_q;
    logic [SYN_W-1:0] syn_q;
    logic             armed;
    logic             hit;

    assign armed = (kind_q == CAP_NONE);
    assign hit   = err_single | err_multi;

    // Status flags: capture when armed (multi-bit wins), else W1C clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= CAP_NONE;
        end else if (armed) begin
            if (err_multi)
                kind_q <= CAP_MBE;
            else if (err_single)
                kind_q <= CAP_SBE;
        end else if (wr_en) begin
            kind_q <= cap_kind_t'(kind_q & ~clr_bits);
        end
    end

    // Address and syndrome fields load only on a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            syn_q  <= '0;
        end else if (armed && hit) begin
            addr_q <= err_addr[ADDR_W-1 -: LOG_W];
            syn_q  <= err_syn;
        end
    end

    assign kind_o = kind_q;
    assign addr_o = addr_q;
    assign syn_o  = syn_q;
endmodule

// File: rtl/ecc_cap_out.sv
// Output conditioning: level interrupt and system-error requests from the
// held status and enables, plus the scrub request for corrected reads.
// Assumes the scrub path accepts a single-cycle combinational request.
module ecc_cap_out
    import ecc_cap_pkg::*;
(
    input  cap_kind_t kind,
    input  ctrl_t     ctrl,
    input  logic      err_single,
    output logic      nmi_req,
    output logic      serr,
    output logic      scrub_req
);
    // Derive the three outward requests
    always_comb begin
        nmi_req   = kind[BIT_SBE] & ctrl.nmi_en;
        serr      = kind[BIT_MBE] & ctrl.serr_en;
        scrub_req = err_single & ~ctrl.scrub_dis;
    end
endmodule

// File: rtl/ecc_err_capture.sv
// ECC error capture register top. Joins the control holder, the first-error
// logger and the output stage, and presents one 32-bit register view.
// Assumes ADDR_W and SYN_W leave exactly the remaining bits for the address.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_single_i,
    input  logic              err_multi_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic [SYN_W-1:0]  err_syn_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              nmi_req_o,
    output logic              serr_o,
    output logic              scrub_req_o
);
    localparam int LOG_W   = BIT_SCRUB_DIS - SYN_LSB - SYN_W;
    localparam int ADR_LSB = SYN_LSB + SYN_W;

    ctrl_t            ctrl;
    cap_kind_t        kind;
    logic [LOG_W-1:0] log_addr;
    logic [SYN_W-1:0] log_syn;

    ecc_cap_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_i),
        .wdata  (reg_wdata_i),
        .ctrl_o (ctrl)
    );

    ecc_cap_log #(
        .ADDR_W (ADDR_W),
        .SYN_W  (SYN_W),
        .LOG_W  (LOG_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_single (err_single_i),
        .err_multi  (err_multi_i),
        .err_addr   (err_addr_i),
        .err_syn    (err_syn_i),
        .wr_en      (reg_wr_i),
        .clr_bits   (reg_wdata_i[BIT_MBE:BIT_SBE]),
        .kind_o     (kind),
        .addr_o     (log_addr),
        .syn_o      (log_syn)
    );

    ecc_cap_out u_out (
        .kind       (kind),
        .ctrl       (ctrl),
        .err_single (err_single_i),
        .nmi_req    (nmi_req_o),
        .serr       (serr_o),
        .scrub_req  (scrub_req_o)
    );

    // Assemble the software-visible register
    always_comb begin
        reg_rdata_o                                  = '0;
        reg_rdata_o[BIT_SCRUB_DIS]                   = ctrl.scrub_dis;
        reg_rdata_o[ADR_LSB +: LOG_W]                = log_addr;
        reg_rdata_o[SYN_LSB +: SYN_W]                = log_syn;
        reg_rdata_o[BIT_SERR_EN]                     = ctrl.serr_en;
        reg_rdata_o[BIT_NMI_EN]                      = ctrl.nmi_en;
        reg_rdata_o[BIT_MBE:BIT_SBE]                 = kind;
    end
endmodule

// File: rtl/ecc_cap_chk.sv
// Property checker for the ECC error capture register, observing ports only.
// Assumes the default register layout from ecc_cap_pkg.
module ecc_cap_chk
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_single_i,
    input logic              err_multi_i,
    input logic [ADDR_W-1:0] err_addr_i,
    input logic [SYN_W-1:0]  err_syn_i,
    input logic              reg_wr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              nmi_req_o,
    input logic              serr_o,
    input logic              scrub_req_o
);
    localparam int LOG_W   = BIT_SCRUB_DIS - SYN_LSB - SYN_W;
    localparam int ADR_LSB = SYN_LSB + SYN_W;

    logic armed;
    logic clearing;
    assign armed    = (reg_rdata_o[1:0] == 2'b00);
    assign clearing = reg_wr_i && ((reg_wdata_i[1:0] & reg_rdata_o[1:0]) != 2'b00);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rdata_o == '0));

    // R3
    sbe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && err_single_i && !err_multi_i) |=>
            (reg_rdata_o[1:0] == 2'b01)
            && (reg_rdata_o[SYN_LSB +: SYN_W] == $past(err_syn_i))
            && (reg_rdata_o[ADR_LSB +: LOG_W] == $past(err_addr_i[ADDR_W-1 -: LOG_W])));

    // R5
    multi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && err_single_i && err_multi_i) |=> (reg_rdata_o[1:0] == 2'b10));

    // R6
    frozen_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !clearing) |=>
            ($stable(reg_rdata_o[30:4]) && $stable(reg_rdata_o[1:0])));

    // R8
    nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o == (reg_rdata_o[BIT_SBE] && reg_rdata_o[BIT_NMI_EN]));

    // R9
    serr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o == (reg_rdata_o[BIT_MBE] && reg_rdata_o[BIT_SERR_EN]));

    // R10
    scrub_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req_o == (err_single_i && !reg_rdata_o[BIT_SCRUB_DIS]));
endmodule

bind ecc_err_capture ecc_cap_chk #(
    .ADDR_W (ADDR_W),
    .SYN_W  (SYN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_single_i (err_single_i),
    .err_multi_i  (err_multi_i),
    .err_addr_i   (err_addr_i),
    .err_syn_i    (err_syn_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .nmi_req_o    (nmi_req_o),
    .serr_o       (serr_o),
    .scrub_req_o  (scrub_req_o)
);

// File: tb/ecc_err_capture_bench.sv
module ecc_err_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_single_i = 1'b0;
    logic        err_multi_i = 1'b0;
    logic [31:0] err_addr_i = '0;
    logic [7:0]  err_syn_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        nmi_req_o, serr_o, scrub_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    logic        m_dis, m_serr_en, m_nmi_en, m_mf, m_sf;
    logic [18:0] m_addr;
    logic [7:0]  m_syn;

    always #5 clk = ~clk;

    ecc_err_capture u_ecc_err_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_single_i (err_single_i),
        .err_multi_i  (err_multi_i),
        .err_addr_i   (err_addr_i),
        .err_syn_i    (err_syn_i),
        .reg_wr_i     (reg_wr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .nmi_req_o    (nmi_req_o),
        .serr_o       (serr_o),
        .scrub_req_o  (scrub_req_o)
    );

    function automatic logic [31:0] exp_reg();
        return {m_dis, m_addr, m_syn, m_serr_en, m_nmi_en, m_mf, m_sf};
    endfunction

    function automatic logic [2:0] exp_outs(input logic single);
        return {m_sf & m_nmi_en, m_mf & m_serr_en, single & ~m_dis};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check scrub, advance model, compare state
    task automatic step(input string tag, input logic s, input logic m,
                        input logic [31:0] a, input logic [7:0] y,
                        input logic w, input logic [31:0] d);
        logic armed;
        @(negedge clk);
        err_single_i = s; err_multi_i = m; err_addr_i = a; err_syn_i = y;
        reg_wr_i = w; reg_wdata_i = d;
        #1;
        check({tag, " R10 scrub"}, {31'd0, scrub_req_o}, {31'd0, exp_outs(s)[0]});
        @(posedge clk);
        armed = !m_sf && !m_mf;
        if (w) begin
            m_dis = d[31]; m_serr_en = d[3]; m_nmi_en = d[2];
            if (!armed) begin
                if (d[1]) m_mf = 1'b0;
                if (d[0]) m_sf = 1'b0;
            end
        end
        if (armed && (s || m)) begin
            m_mf = m; m_sf = !m; m_addr = a[31:13]; m_syn = y;
        end
        @(negedge clk);
        err_single_i = 1'b0; err_multi_i = 1'b0; reg_wr_i = 1'b0;
        #1;
        check(tag, reg_rdata_o, exp_reg());
        check({tag, " R8/R9 levels"}, {30'd0, nmi_req_o, serr_o}, {30'd0, exp_outs(1'b0)[2:1]});
    endtask

    task automatic wr(input string tag, input logic [31:0] d);
        step(tag, 1'b0, 1'b0, 32'h0, 8'h0, 1'b1, d);
    endtask

    task automatic err(input string tag, input logic s, input logic m,
                       input logic [31:0] a, input logic [7:0] y);
        step(tag, s, m, a, y, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_dis = 0; m_serr_en = 0; m_nmi_en = 0; m_mf = 0; m_sf = 0; m_addr = '0; m_syn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset reg", reg_rdata_o, 32'h0);
        check("R1 reset outs", {29'd0, nmi_req_o, serr_o, scrub_req_o}, 32'h0);

        wr("R2 set ctrl", 32'h8000_000C);
        check("R2 readback", reg_rdata_o, 32'h8000_000C);
        wr("R2 clear ctrl", 32'h0000_0000);
        err("R3 single capture", 1'b1, 1'b0, 32'hABCD_E123, 8'h5A);
        check("R3 fields", reg_rdata_o, {1'b0, 19'h55E6F, 8'h5A, 4'b0001});
        err("R6 later multi ignored", 1'b0, 1'b1, 32'h1234_5678, 8'hC3);
        wr("R7 write 0s no clear", 32'h0000_0000);
        wr("R7 clear other flag", 32'h0000_0002);
        wr("R8 nmi enable", 32'h0000_0004);
        check("R8 nmi high", {31'd0, nmi_req_o}, 32'h1);
        wr("R7 W1C single", 32'h0000_0005);
        err("R5 both same cycle", 1'b1, 1'b1, 32'hFFFF_E000, 8'h81);
        check("R5 only multi", {30'd0, reg_rdata_o[1:0]}, 32'h2);
        wr("R9 serr enable", 32'h0000_0008);
        check("R9 serr high", {31'd0, serr_o}, 32'h1);
        wr("R7 W1C multi", 32'h0000_000A);
        err("R4 multi capture", 1'b0, 1'b1, 32'h0000_2000, 8'hFF);
        step("R6 error during clear ignored", 1'b1, 1'b0, 32'h7777_7777, 8'h11, 1'b1, 32'h0000_0003);
        check("R6 rearmed empty", {30'd0, reg_rdata_o[1:0]}, 32'h0);
        step("R11 write with error", 1'b1, 1'b0, 32'h8000_0000, 8'h3C, 1'b1, 32'h8000_0004);
        err("R10 scrub disabled", 1'b1, 1'b0, 32'h0, 8'h0);
        wr("R7 clear all", 32'h0000_0003);

        for (int i = 0; i < 600; i++) begin
            logic s, m, w;
            logic [31:0] d;
            s = ($urandom_range(0, 3) == 0);
            m = ($urandom_range(0, 5) == 0);
            w = ($urandom_range(0, 2) == 0);
            d = $urandom();
            step("R6 random", s, m, $urandom(), 8'($urandom()), w, d);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule